// File: doc/BRIEF.md
# VLIW Issue Sequencer with Temporal Repeat

This block is the control front end of one compute lane. It holds a program of very long instruction words in a local buffer and issues one word per clock. Each word carries a control operation plus an ALU operation and a load/store operation for each of four slices. The sequencer does not send a word to several lanes at once. Instead it can replay the same word on consecutive cycles while an element index counts up. Successive replays then address consecutive elements of the vector registers.

The number of replays comes from a repeat field in the word. This field is either an immediate inside the word or the value of a scalar register that the sequencer selects. The count is capped at the vector length of 32. The control operation can end a run with a halt, or redirect the program counter with a branch once the branching word has finished all its replays. A stall input freezes issue without losing place. A start pulse launches the program at a given address. A plain write port fills the buffer.

Top module: `vliw_issue_seq`

## Requirements
- R1: After synchronous reset, issue_valid and done are 0 and remain 0 until a start pulse is given.
- R2: A 93-bit word has these fields. Control operation at [92:85], and its top two bits [92:91] are the kind: 00 plain, 01 branch, 10 halt, 11 plain. Branch target at [84:76]. Dynamic-repeat flag at [75]. Repeat immediate at [74:69]. Scalar register select at [68:64]. Slice s has its ALU op at [16s+15:16s+8] and its LSU op at [16s+7:16s]. Each issue puts the word's control op on issue_ctl, ALU op s on issue_alu[8s+7:8s] and LSU op s on issue_lsu[8s+7:8s].
- R3: Start is sampled at a rising edge while the block is not running. It fetches from start_pc, and issue_valid rises at the next rising edge with issue_pc equal to start_pc.
- R4: With the dynamic flag at 0, the word is issued max(1, min(imm, 32)) times on consecutive unstalled cycles, so 0 and 1 both give one issue.
- R5: With the dynamic flag at 1, sreg_sel shows the word's register select field. The repeat count is taken from sreg_val with the same rule as R4: 0 gives one issue, and values above 32 give 32. The immediate is ignored.
- R6: During the replays of a word, issue_pc stays fixed and issue_elem takes the values 0, 1, 2 and onward in order. The next word starts again at element 0.
- R7: After the last replay of a plain word, the next word issued is at program counter + 1.
- R8: A branch word is issued for all its replays like a plain word, and the next word issued is the one at its target address.
- R9: A halt word is never issued. When it is reached, done rises and issue_valid stays 0 until the next start, and that start clears done.
- R10: A cycle whose rising edge sees stall at 1 issues nothing, so issue_valid is 0 after that edge. The program counter, element index and repeat count hold their values, and issue resumes with the element that was due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable for the instruction buffer |
| wr_addr | input | 9 | Instruction buffer write address |
| wr_data | input | 93 | Instruction word to write |
| start | input | 1 | Launch pulse, ignored while running |
| start_pc | input | 9 | First address to fetch on launch |
| stall | input | 1 | Freeze issue for this cycle |
| sreg_sel | output | 5 | Scalar register select for the dynamic repeat count |
| sreg_val | input | 64 | Value of the selected scalar register |
| issue_valid | output | 1 | An instruction word is being issued |
| issue_pc | output | 9 | Address of the issued word |
| issue_elem | output | 5 | Vector element index of this replay |
| issue_ctl | output | 8 | Control operation of the issued word |
| issue_alu | output | 32 | ALU operations, one byte per slice |
| issue_lsu | output | 32 | LSU operations, one byte per slice |
| done | output | 1 | A halt word has been reached |

## Verification
The assertions check several rules on every cycle. The element index steps by exactly one while the program counter stays put. A new program counter always begins at element 0. A stalled edge is always followed by a cycle with no issue. Done never coincides with an issue and persists until a start. The replay totals from the clamp rule, the choice of immediate over register, the fields routed to each slice, the taken branch target and the resume point after a stall can only be shown by the bench's scenarios. Those scenarios run whole programs and compare the recorded issue stream with the expected one.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int SLICES = 4;
  localparam int OP_W   = 8;
  localparam int CTL_W  = 8;
  localparam int PC_W   = 9;
  localparam int REP_W  = 6;
  localparam int SEL_W  = 5;

  typedef enum logic [1:0] {
    CK_PLAIN  = 2'b00,
    CK_BRANCH = 2'b01,
    CK_HALT   = 2'b10,
    CK_SPARE  = 2'b11
  } ctl_kind_e;

  typedef struct packed {
    logic [OP_W-1:0] alu;
    logic [OP_W-1:0] lsu;
  } slice_op_t;

  typedef struct packed {
    logic [CTL_W-1:0]           ctl;
    logic [PC_W-1:0]            target;
    logic                       rep_dyn;
    logic [REP_W-1:0]           rep_imm;
    logic [SEL_W-1:0]           rep_sel;
    slice_op_t [SLICES-1:0]     slices;
  } vliw_t;

  localparam int VLIW_W = $bits(vliw_t);

  function automatic ctl_kind_e kind_of(input logic [CTL_W-1:0] c);
    return ctl_kind_e'(c[CTL_W-1 -: 2]);
  endfunction
endpackage

// File: rtl/vseq_ibuf.sv
module vseq_ibuf #(
  parameter int AW = 9,
  parameter int W  = 93,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/vseq_rep_count.sv
module vseq_rep_count #(
  parameter int VLEN   = 32,
  parameter int SREG_W = 64,
  parameter int IMM_W  = 6,
  localparam int CNT_W = $clog2(VLEN) + 1
) (
  input  logic              dyn,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SREG_W-1:0] sreg_val,
  output logic [CNT_W-1:0]  total
);
  localparam logic [SREG_W-1:0] LIMIT = SREG_W'(VLEN);

  logic [SREG_W-1:0] raw;

  always_comb begin
    raw = dyn ? sreg_val : {{(SREG_W-IMM_W){1'b0}}, imm};
    if (raw == '0)
      total = CNT_W'(1);
    else if (raw > LIMIT)
      total = CNT_W'(VLEN);
    else
      total = raw[CNT_W-1:0];
  end
endmodule

// File: rtl/vseq_rep_track.sv
module vseq_rep_track #(
  parameter int VLEN = 32,
  localparam int IDX_W = $clog2(VLEN),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] total_in,
  output logic [IDX_W-1:0] elem,
  output logic             last
);
  logic [IDX_W-1:0] elem_q;
  logic [CNT_W-1:0] total_q;
  logic             first;
  logic [CNT_W-1:0] total_now;

  always_comb begin
    first     = (elem_q == '0);
    total_now = first ? total_in : total_q;
    last      = (({1'b0, elem_q} + 1'b1) == total_now);
    elem      = elem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elem_q  <= '0;
      total_q <= CNT_W'(1);
    end else if (clear) begin
      elem_q  <= '0;
    end else if (step) begin
      if (first) total_q <= total_in;
      elem_q <= last ? '0 : elem_q + 1'b1;
    end
  end
endmodule

// File: rtl/vliw_issue_seq.sv
module vliw_issue_seq
  import vseq_pkg::*;
#(
  parameter int VLEN   = 32,
  parameter int SREG_W = 64,
  localparam int IDX_W = $clog2(VLEN),
  localparam int CNT_W = IDX_W + 1,
  localparam int OPS_W = SLICES * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_addr,
  input  logic [VLIW_W-1:0] wr_data,
  input  logic              start,
  input  logic [PC_W-1:0]   start_pc,
  input  logic              stall,
  output logic [SEL_W-1:0]  sreg_sel,
  input  logic [SREG_W-1:0] sreg_val,
  output logic              issue_valid,
  output logic [PC_W-1:0]   issue_pc,
  output logic [IDX_W-1:0]  issue_elem,
  output logic [CTL_W-1:0]  issue_ctl,
  output logic [OPS_W-1:0]  issue_alu,
  output logic [OPS_W-1:0]  issue_lsu,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HALTED} seq_state_e;

  seq_state_e        state_q;
  logic [PC_W-1:0]   pc_q;
  logic [VLIW_W-1:0] word_raw;
  vliw_t             word;
  ctl_kind_e         kind;
  logic              launch, issue_go, halt_hit, advance;
  logic [PC_W-1:0]   next_pc;
  logic              rd_en;
  logic [PC_W-1:0]   rd_addr;
  logic [CNT_W-1:0]  total;
  logic [IDX_W-1:0]  elem;
  logic              last;
  logic [OPS_W-1:0]  alu_flat, lsu_flat;

  vseq_ibuf #(.AW(PC_W), .W(VLIW_W)) u_ibuf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(word_raw)
  );

  assign word     = vliw_t'(word_raw);
  assign kind     = kind_of(word.ctl);
  assign sreg_sel = word.rep_sel;

  vseq_rep_count #(.VLEN(VLEN), .SREG_W(SREG_W), .IMM_W(REP_W)) u_count (
    .dyn(word.rep_dyn), .imm(word.rep_imm), .sreg_val(sreg_val), .total(total)
  );

  vseq_rep_track #(.VLEN(VLEN)) u_track (
    .clk(clk), .rst(rst), .clear(launch), .step(issue_go),
    .total_in(total), .elem(elem), .last(last)
  );

  genvar s;
  generate
    for (s = 0; s < SLICES; s++) begin : g_slice
      assign alu_flat[s*OP_W +: OP_W] = word.slices[s].alu;
      assign lsu_flat[s*OP_W +: OP_W] = word.slices[s].lsu;
    end
  endgenerate

  always_comb begin
    launch   = start && (state_q != S_RUN);
    halt_hit = (state_q == S_RUN) && !stall && (kind == CK_HALT);
    issue_go = (state_q == S_RUN) && !stall && (kind != CK_HALT);
    advance  = issue_go && last;
    next_pc  = (kind == CK_BRANCH) ? word.target : pc_q + 1'b1;
    rd_en    = launch || advance;
    rd_addr  = launch ? start_pc : next_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      pc_q        <= '0;
      done        <= 1'b0;
      issue_valid <= 1'b0;
      issue_pc    <= '0;
      issue_elem  <= '0;
      issue_ctl   <= '0;
      issue_alu   <= '0;
      issue_lsu   <= '0;
    end else begin
      issue_valid <= issue_go;
      if (issue_go) begin
        issue_pc   <= pc_q;
        issue_elem <= elem;
        issue_ctl  <= word.ctl;
        issue_alu  <= alu_flat;
        issue_lsu  <= lsu_flat;
      end
      if (launch) begin
        state_q <= S_RUN;
        pc_q    <= start_pc;
        done    <= 1'b0;
      end else if (halt_hit) begin
        state_q <= S_HALTED;
        done    <= 1'b1;
      end else if (advance) begin
        pc_q <= next_pc;
      end
    end
  end
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int VLEN = 32,
  parameter int PC_W = 9,
  localparam int IDX_W = $clog2(VLEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             stall,
  input logic             issue_valid,
  input logic [PC_W-1:0]  issue_pc,
  input logic [IDX_W-1:0] issue_elem,
  input logic             done
);
  // R6
  elem_step_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && issue_elem != '0)
      |-> (issue_elem == IDX_W'($past(issue_elem) + 1'b1)));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && issue_elem != '0)
      |-> (issue_pc == $past(issue_pc)));

  // R6
  new_word_elem_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && issue_pc != $past(issue_pc))
      |-> (issue_elem == '0));

  // R10
  stall_gap_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !issue_valid);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !issue_valid);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

bind vliw_issue_seq vseq_chk #(.VLEN(VLEN), .PC_W(vseq_pkg::PC_W)) u_vseq_chk (
  .clk(clk), .rst(rst), .start(start), .stall(stall),
  .issue_valid(issue_valid), .issue_pc(issue_pc),
  .issue_elem(issue_elem), .done(done)
);

// File: tb/test_vliw_issue_seq.sv
module test_vliw_issue_seq;
  localparam int W = vseq_pkg::VLIW_W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [8:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          start = 1'b0;
  logic [8:0]    start_pc = '0;
  logic          stall = 1'b0;
  logic [4:0]    sreg_sel;
  logic [63:0]   sreg_val = '0;
  logic          issue_valid;
  logic [8:0]    issue_pc;
  logic [4:0]    issue_elem;
  logic [7:0]    issue_ctl;
  logic [31:0]   issue_alu;
  logic [31:0]   issue_lsu;
  logic          done;

  always #5 clk = ~clk;

  vliw_issue_seq i_vliw_issue_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .start_pc(start_pc), .stall(stall), .sreg_sel(sreg_sel),
    .sreg_val(sreg_val), .issue_valid(issue_valid), .issue_pc(issue_pc),
    .issue_elem(issue_elem), .issue_ctl(issue_ctl), .issue_alu(issue_alu),
    .issue_lsu(issue_lsu), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int rec_pc[128];
  int rec_elem[128];
  int rec_ctl[128];
  logic [31:0] rec_alu[128];
  logic [31:0] rec_lsu[128];
  int rec_sel;
  int n_rec;

  typedef struct packed {
    logic        dyn;
    logic [5:0]  imm;
    logic [15:0] sreg;
    logic [5:0]  exp_n;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 6'd0,  16'd0,    6'd1},
    '{1'b0, 6'd1,  16'd0,    6'd1},
    '{1'b0, 6'd5,  16'd0,    6'd5},
    '{1'b0, 6'd32, 16'd0,    6'd32},
    '{1'b0, 6'd45, 16'd0,    6'd32},
    '{1'b1, 6'd9,  16'd0,    6'd1},
    '{1'b1, 6'd9,  16'd7,    6'd7},
    '{1'b1, 6'd9,  16'd32,   6'd32},
    '{1'b1, 6'd9,  16'd1000, 6'd32},
    '{1'b1, 6'd9,  16'd33,   6'd32}
  };

  function automatic logic [W-1:0] mk_word(input logic [1:0] kind, input logic [8:0] tgt,
                                           input logic dyn, input logic [5:0] imm,
                                           input logic [4:0] sel, input logic [7:0] seed);
    logic [W-1:0] w;
    w = '0;
    w[92:85] = {kind, seed[5:0]};
    w[84:76] = tgt;
    w[75]    = dyn;
    w[74:69] = imm;
    w[68:64] = sel;
    for (int s = 0; s < 4; s++) begin
      w[16*s+8 +: 8] = 8'(seed + 8'(16*s) + 8'd1);
      w[16*s   +: 8] = 8'(seed + 8'(16*s) + 8'd2);
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_ops(input logic [7:0] seed, input int off);
    logic [31:0] v;
    for (int s = 0; s < 4; s++) v[8*s +: 8] = 8'(seed + 8'(16*s) + 8'(off));
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [W-1:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'(addr); wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Launch at pc and record the issue stream until done; optional stall window.
  task automatic run_collect(input int pc, input int stall_at, input int stall_len);
    bit stalled_once = 0;
    bit stall_on = 0;
    int left = 0;
    n_rec = 0;
    @(negedge clk);
    start = 1'b1; start_pc = 9'(pc);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 300; c++) begin
      if (done) break;
      rec_sel = int'(sreg_sel);
      if (stall_on) begin
        check("R10 no issue while stalled", issue_valid, 0);
        left--;
        if (left == 0) begin stall = 1'b0; stall_on = 0; end
      end else if (issue_valid && n_rec < 128) begin
        rec_pc[n_rec] = int'(issue_pc);
        rec_elem[n_rec] = int'(issue_elem);
        rec_ctl[n_rec] = int'(issue_ctl);
        rec_alu[n_rec] = issue_alu;
        rec_lsu[n_rec] = issue_lsu;
        n_rec++;
      end
      if (!stalled_once && stall_at >= 0 && n_rec == stall_at) begin
        stall = 1'b1; stall_on = 1; left = stall_len; stalled_once = 1;
      end
      @(negedge clk);
    end
    check("R9 done reached", done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", issue_valid, 0);
    check("R1 done after reset", done, 0);
    repeat (4) @(negedge clk);
    check("R1 idle without start", issue_valid, 0);

    // Vector table: repeat counts, static and dynamic
    for (int i = 0; i < 10; i++) begin
      logic [7:0] seed;
      logic [4:0] sel;
      seed = 8'(8'h20 + 8'(i));
      sel  = 5'(3 + i);
      wr(0, mk_word(2'b00, 9'd0, VECS[i].dyn, VECS[i].imm, sel, seed));
      wr(1, mk_word(2'b10, 9'd0, 1'b0, 6'd0, sel, 8'h00));
      sreg_val = 64'(VECS[i].sreg);
      run_collect(0, -1, 0);
      if (VECS[i].dyn) check("R5 dynamic repeat count", n_rec, int'(VECS[i].exp_n));
      else             check("R4 static repeat count", n_rec, int'(VECS[i].exp_n));
      if (VECS[i].dyn) check("R5 register select", rec_sel, int'(sel));
      bad = 0;
      for (int k = 0; k < n_rec; k++)
        if (rec_elem[k] != k || rec_pc[k] != 0) bad++;
      check("R6 element sequence", bad, 0);
      check("R2 ctl field", rec_ctl[0], int'({2'b00, seed[5:0]}));
      check("R2 alu fields", rec_alu[0], exp_ops(seed, 1));
      check("R2 lsu fields", rec_lsu[0], exp_ops(seed, 2));
    end

    // R3 start latency
    wr(20, mk_word(2'b00, 9'd0, 1'b0, 6'd2, 5'd0, 8'h41));
    wr(21, mk_word(2'b10, 9'd0, 1'b0, 6'd0, 5'd0, 8'h00));
    @(negedge clk);
    start = 1'b1; start_pc = 9'd20;
    @(negedge clk);
    start = 1'b0;
    check("R9 start clears done", done, 0);
    check("R3 no issue on launch edge", issue_valid, 0);
    @(negedge clk);
    check("R3 first issue next edge", issue_valid, 1);
    check("R3 first issue pc", issue_pc, 20);
    repeat (5) @(negedge clk);
    check("R9 done after halt", done, 1);
    check("R9 quiet after halt", issue_valid, 0);

    // R7 / R8 branch and sequential flow
    wr(40, mk_word(2'b01, 9'd50, 1'b0, 6'd3, 5'd0, 8'h51));
    wr(41, mk_word(2'b10, 9'd0, 1'b0, 6'd0, 5'd0, 8'h00));
    wr(50, mk_word(2'b00, 9'd0, 1'b0, 6'd2, 5'd0, 8'h52));
    wr(51, mk_word(2'b11, 9'd7, 1'b0, 6'd1, 5'd0, 8'h53));
    wr(52, mk_word(2'b10, 9'd0, 1'b0, 6'd0, 5'd0, 8'h00));
    run_collect(40, -1, 0);
    check("R8 branch stream length", n_rec, 6);
    bad = 0;
    for (int k = 0; k < 3; k++) if (rec_pc[k] != 40 || rec_elem[k] != k) bad++;
    check("R8 branch word replays", bad, 0);
    check("R8 target after replays", rec_pc[3], 50);
    check("R6 element restarts", rec_elem[3], 0);
    check("R7 sequential next", rec_pc[5], 51);
    check("R7 spare kind is plain", rec_elem[5], 0);

    // R10 stall mid-repeat
    wr(60, mk_word(2'b00, 9'd0, 1'b0, 6'd4, 5'd0, 8'h61));
    wr(61, mk_word(2'b10, 9'd0, 1'b0, 6'd0, 5'd0, 8'h00));
    run_collect(60, 2, 3);
    check("R10 issue count with stall", n_rec, 4);
    bad = 0;
    for (int k = 0; k < n_rec; k++) if (rec_elem[k] != k || rec_pc[k] != 60) bad++;
    check("R10 resume element", bad, 0);

    // R9 done persists
    repeat (6) @(negedge clk);
    check("R9 done holds", done, 1);
    check("R9 still quiet", issue_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule